// File: doc/BRIEF.md
# Saturating Signed Add/Subtract Unit with Doubling

This block is a registered signed arithmetic unit for fixed-point signal processing. Each clock it takes two signed operands and an operation code. It produces a result that never wraps around. Any result that leaves the signed range is clamped to the nearest limit.

Two of the four operations first double the second operand. That doubled value is itself clamped before the final add or subtract, so there are two places where saturation can happen.

Every saturation drives a one-cycle pulse. The pulse also sets a sticky flag inside the block. Only reset or an explicit clear input brings the flag back to zero, so software-visible logic elsewhere can poll it after a long run of samples.

Top module: `sat_dsp_unit`

## Requirements
- R1: With `op_sel` = 00 the result is `opa + opb`; on signed overflow it is clamped to the most positive value (0x7FFFFFFF) when the true sum is positive and to the most negative value (0x80000000) when it is negative.
- R2: With `op_sel` = 01 the result is `opa - opb`, clamped to 0x80000000 or 0x7FFFFFFF under the same rule when the difference leaves the signed range.
- R3: With `op_sel` = 10 the result is `opa` plus the clamped double of `opb`, saturated again on overflow.
- R4: With `op_sel` = 11 the result is `opa` minus the clamped double of `opb`, saturated again on overflow.
- R5: In the doubling operations, `opb + opb` is clamped to the signed limit before it reaches the second stage. For example, `opa` = 0xFFFFFFFF with doubling add and `opb` = 0x40000000 gives 0x7FFFFFFE, not a saturated final value.
- R6: Result, pulse and flag are registered. Inputs applied before a rising edge show on the outputs after that edge and not before it.
- R7: `sat_pulse` is high for the cycle after an operation that saturated in either stage. An overflow of the doubling stage is ignored by the plain add and subtract operations.
- R8: `sat_sticky` is set by any saturation and stays set through later operations that do not saturate.
- R9: `clr_sticky` clears the flag on the next edge. When a saturation occurs in the same cycle as the clear, the flag is set instead.
- R10: A synchronous active-high `rst` drives the result, the pulse and the flag to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| clr_sticky | input | 1 | Clears the sticky saturation flag |
| op_sel | input | 2 | 00 add, 01 subtract, 10 doubling add, 11 doubling subtract |
| opa | input | W (32) | First signed operand |
| opb | input | W (32) | Second signed operand (the one doubled) |
| result | output | W (32) | Registered saturated result |
| sat_pulse | output | 1 | One-cycle indication that the last operation saturated |
| sat_sticky | output | 1 | Sticky saturation flag |

## Verification
Some properties are checked on every cycle. A final-stage overflow always leaves a limit value on `result`. A pulse always comes with the flag set. The flag holds unless it is cleared. A clear without a concurrent saturation drops it. A plain operation can never report a doubling overflow.

The arithmetic values themselves can only be shown by the bench's scenarios. These compare every registered output against a wide-integer reference model. They cover:
- the exact clamp points,
- the case where the doubled operand clamps but the final sum does not,
- a saturation and a clear in the same cycle,
- a reset in the middle of a run.

// File: rtl/sat_pkg.sv
package sat_pkg;
  typedef enum logic [1:0] {
    OP_ADD  = 2'b00,
    OP_SUB  = 2'b01,
    OP_DADD = 2'b10,
    OP_DSUB = 2'b11
  } sat_op_e;
endpackage

// File: rtl/sat_addsub.sv
module sat_addsub #(
  parameter int W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         sub,
  output logic [W-1:0] y,
  output logic         ovf
);
  localparam logic [W-1:0] MAXV = {1'b0, {(W-1){1'b1}}};
  localparam logic [W-1:0] MINV = {1'b1, {(W-1){1'b0}}};

  function automatic logic [W-1:0] wrap_op(input logic [W-1:0] x, input logic [W-1:0] z,
                                           input logic s);
    return s ? (x - z) : (x + z);
  endfunction

  function automatic logic ovf_det(input logic [W-1:0] x, input logic [W-1:0] z,
                                   input logic [W-1:0] r, input logic s);
    logic same_sign;
    same_sign = (x[W-1] == z[W-1]);
    return (s ? !same_sign : same_sign) && (r[W-1] != x[W-1]);
  endfunction

  // a wrapped result that looks non-negative came from a negative overflow
  function automatic logic [W-1:0] clamp_of(input logic [W-1:0] r);
    return r[W-1] ? MAXV : MINV;
  endfunction

  logic [W-1:0] raw;

  always_comb begin
    raw = wrap_op(a, b, sub);
    ovf = ovf_det(a, b, raw, sub);
    y   = ovf ? clamp_of(raw) : raw;
  end
endmodule

// File: rtl/sat_sticky.sv
module sat_sticky (
  input  logic clk,
  input  logic rst,
  input  logic set,
  input  logic clr,
  output logic q
);
  always_ff @(posedge clk) begin
    if (rst)      q <= 1'b0;
    else if (set) q <= 1'b1;
    else if (clr) q <= 1'b0;
  end

  // R8
  sticky_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (q && !clr) |=> q);
  // R9
  sticky_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (clr && !set) |=> !q);
endmodule

// File: rtl/sat_dsp_unit.sv
module sat_dsp_unit #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr_sticky,
  input  logic [1:0]   op_sel,
  input  logic [W-1:0] opa,
  input  logic [W-1:0] opb,
  output logic [W-1:0] result,
  output logic         sat_pulse,
  output logic         sat_sticky
);
  import sat_pkg::*;

  localparam logic [W-1:0] MAXV = {1'b0, {(W-1){1'b1}}};
  localparam logic [W-1:0] MINV = {1'b1, {(W-1){1'b0}}};

  sat_op_e      op;
  logic         is_dbl;
  logic         is_sub;
  logic [W-1:0] dbl_val;
  logic         dbl_ovf;
  logic [W-1:0] rhs;
  logic [W-1:0] fin_val;
  logic         fin_ovf;
  logic         dbl_evt;
  logic         sat_now;

  always_comb begin
    op     = sat_op_e'(op_sel);
    is_dbl = (op == OP_DADD) || (op == OP_DSUB);
    is_sub = (op == OP_SUB)  || (op == OP_DSUB);
  end

  // stage 1: opb + opb with its own clamp
  sat_addsub #(.W(W)) u_dbl (
    .a(opb), .b(opb), .sub(1'b0), .y(dbl_val), .ovf(dbl_ovf)
  );

  assign rhs = is_dbl ? dbl_val : opb;

  // stage 2: opa +/- rhs with the final clamp
  sat_addsub #(.W(W)) u_fin (
    .a(opa), .b(rhs), .sub(is_sub), .y(fin_val), .ovf(fin_ovf)
  );

  assign dbl_evt = is_dbl && dbl_ovf;
  assign sat_now = fin_ovf || dbl_evt;

  always_ff @(posedge clk) begin
    if (rst) begin
      result    <= '0;
      sat_pulse <= 1'b0;
    end else begin
      result    <= fin_val;
      sat_pulse <= sat_now;
    end
  end

  sat_sticky u_flag (
    .clk(clk), .rst(rst), .set(sat_now), .clr(clr_sticky), .q(sat_sticky)
  );

  // R1 R2 R3 R4
  fin_clamp_chk: assert property (@(posedge clk) disable iff (rst)
    fin_ovf |=> (result == MAXV || result == MINV));
  // R7
  plain_no_dbl_chk: assert property (@(posedge clk) disable iff (rst)
    (!is_dbl && !fin_ovf) |=> !sat_pulse);
  // R8
  pulse_sets_flag_chk: assert property (@(posedge clk) disable iff (rst)
    sat_pulse |-> sat_sticky);
  // R10
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (result == '0 && !sat_pulse && !sat_sticky));
endmodule

// File: tb/sat_dsp_unit_test.sv
`timescale 1ns/1ps
module sat_dsp_unit_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        clr_sticky = 1'b0;
  logic [1:0]  op_sel = 2'b00;
  logic [31:0] opa = '0;
  logic [31:0] opb = '0;
  logic [31:0] result;
  logic        sat_pulse;
  logic        sat_sticky;

  int vectors = 0;
  int fails = 0;

  logic [31:0] exp_res = '0;
  bit          exp_pulse = 1'b0;
  bit          exp_stk = 1'b0;

  always #2.5 clk = ~clk;

  sat_dsp_unit #(.W(32)) uut (
    .clk(clk), .rst(rst), .clr_sticky(clr_sticky), .op_sel(op_sel),
    .opa(opa), .opb(opb), .result(result), .sat_pulse(sat_pulse),
    .sat_sticky(sat_sticky)
  );

  localparam longint HI = 64'sd2147483647;
  localparam longint LO = -64'sd2147483648;

  function automatic bit outside(longint v);
    return (v > HI) || (v < LO);
  endfunction

  function automatic longint limit(longint v);
    if (v > HI) return HI;
    if (v < LO) return LO;
    return v;
  endfunction

  function automatic string tag_of(logic [1:0] o);
    case (o)
      2'b00:   return "R1";
      2'b01:   return "R2";
      2'b10:   return "R3";
      default: return "R4";
    endcase
  endfunction

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] expv);
    vectors++;
    if (act !== expv) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, expv);
    end
  endtask

  // drive at negedge, one rising edge, compare at the following negedge
  task automatic apply(logic [1:0] o, logic [31:0] a, logic [31:0] b, bit clr);
    longint sa, sb, rhs, r;
    bit d_hit, f_hit;
    op_sel = o; opa = a; opb = b; clr_sticky = clr;
    #1;
    // R6: nothing moves before the edge
    check("R6", "result before edge", result, exp_res);
    sa = longint'($signed(a));
    sb = longint'($signed(b));
    d_hit = o[1] && outside(sb * 2);
    rhs   = o[1] ? limit(sb * 2) : sb;
    r     = o[0] ? (sa - rhs) : (sa + rhs);
    f_hit = outside(r);
    exp_res   = 32'(limit(r));
    exp_pulse = d_hit || f_hit;
    if (exp_pulse)  exp_stk = 1'b1;
    else if (clr)   exp_stk = 1'b0;
    @(posedge clk);
    @(negedge clk);
    check(tag_of(o), "result", result, exp_res);
    check("R7", "sat_pulse", {31'b0, sat_pulse}, {31'b0, exp_pulse});
    check(clr ? "R9" : "R8", "sat_sticky", {31'b0, sat_sticky}, {31'b0, exp_stk});
  endtask

  task automatic do_reset();
    rst = 1'b1; clr_sticky = 1'b0;
    @(posedge clk); @(posedge clk);
    @(negedge clk);
    exp_res = '0; exp_pulse = 1'b0; exp_stk = 1'b0;
    check("R10", "reset result", result, 32'h0);
    check("R10", "reset pulse", {31'b0, sat_pulse}, 32'h0);
    check("R10", "reset sticky", {31'b0, sat_sticky}, 32'h0);
    rst = 1'b0;
  endtask

  initial begin
    #1000000;
    fails++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    @(negedge clk);
    do_reset();
    // R1 plain add, in range and both clamp directions
    apply(2'b00, 32'd5, 32'd7, 1'b0);
    apply(2'b00, 32'h7FFFFFFF, 32'd1, 1'b0);
    apply(2'b00, 32'h80000000, 32'hFFFFFFFF, 1'b0);
    // R8 flag stays set through clean operations
    apply(2'b00, 32'd1, 32'd1, 1'b0);
    apply(2'b01, 32'd10, 32'd3, 1'b0);
    // R9 clear
    apply(2'b00, 32'd1, 32'd1, 1'b1);
    // R2 subtract clamps
    apply(2'b01, 32'h80000000, 32'd1, 1'b0);
    apply(2'b01, 32'h7FFFFFFF, 32'hFFFFFFFF, 1'b0);
    apply(2'b01, 32'h00000000, 32'h80000000, 1'b0);
    // R9 saturation wins over a concurrent clear
    apply(2'b01, 32'h80000000, 32'h7FFFFFFF, 1'b1);
    apply(2'b00, 32'd0, 32'd0, 1'b1);
    // R7 plain add ignores a doubling overflow of opb
    apply(2'b00, 32'd0, 32'h60000000, 1'b0);
    apply(2'b01, 32'd0, 32'hC0000000, 1'b0);
    // R3 doubling add: clean, final clamp
    apply(2'b10, 32'd100, 32'd21, 1'b0);
    apply(2'b10, 32'h40000000, 32'h20000000, 1'b0);
    apply(2'b00, 32'd0, 32'd0, 1'b1);
    // R5 doubling clamps while the final sum stays in range
    apply(2'b10, 32'hFFFFFFFF, 32'h40000000, 1'b0);
    apply(2'b00, 32'd0, 32'd0, 1'b1);
    apply(2'b10, 32'h00000001, 32'h80000000, 1'b0);
    // R4 doubling subtract
    apply(2'b11, 32'd50, 32'd5, 1'b0);
    apply(2'b11, 32'h00000000, 32'hC0000000, 1'b0);
    apply(2'b11, 32'h80000000, 32'h00000001, 1'b0);
    apply(2'b11, 32'hFFFFFFFF, 32'hBFFFFFFF, 1'b1);
    // R10 reset mid-run with the flag set
    apply(2'b00, 32'h7FFFFFFF, 32'h7FFFFFFF, 1'b0);
    do_reset();
    // mixed patterns, some near the limits
    for (int i = 0; i < 400; i++) begin
      logic [31:0] a, b;
      a = $urandom();
      b = $urandom();
      if (i % 4 == 1) b = {2'b01, b[29:0]};
      if (i % 4 == 2) a = {a[31], {3{a[30]}}, a[27:0]};
      apply(2'(i + (i >> 3)), a, b, (i % 7) == 3);
    end
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule